// File: doc/BRIEF.md
# Serial Audio Link Frame Transmitter

This block is the transmitting half of a controller that talks to an audio codec over a time-division multiplexed serial link. It runs on the link bit clock and changes its outputs on the rising edge only, so the codec can capture them on the falling edge. It repeats a fixed-length frame: a short tag slot and then a row of equal-width data slots. It also drives a frame-sync output that goes high one bit before each frame begins and stays high for as many clocks as the tag slot is long.

Once per frame, at the frame boundary, the block offers a one-clock load window. A producer presents a slot-valid mask, a codec identifier and all slot words at once. If the producer accepts the window, the block builds the tag slot from those inputs. The tag holds a frame-valid bit, a valid flag for each slot, a reserved zero and the identifier. Slots whose flag is clear are sent as zeros. If the window passes with no load, the block sends an empty frame. With the default parameters the frame is 256 bits: a 16-bit tag and twelve 20-bit slots, which at a 12.288 MHz bit clock gives a 48 kHz frame rate. Bit 19 of slot 1 is where the command read/write flag sits.

Top module: `aclink_frame_tx`

## Requirements
- R1: `sync_o` goes high on the rising edge that drives the last frame position F(FRAME-1). It stays high for TAG_W clocks, which are positions F(FRAME-1) and F0 to F(TAG_W-2), and it is low at every other position. The pattern repeats every FRAME = TAG_W + SLOTS*SLOT_W clocks.
- R2: While `rst_i` is high, `sync_o`, `sdout_o` and `ld_ready_o` are all 0. The first load window opens one clock after reset is released.
- R3: `ld_ready_o` is high only for the clock in which F(FRAME-1) is on the line. When `ld_valid_i` is high in that clock, the next rising edge takes the inputs and drives F0 of the frame built from them.
- R4: F0 (frame valid) is 1 exactly when at least one bit of the loaded mask is 1.
- R5: Tag position Fk, for k from 1 to SLOTS, carries `ld_mask_i[k-1]`, the valid flag of slot k.
- R6: The tag positions between the last slot flag and the identifier (F13 with the default parameters) are always 0.
- R7: The last ID_W tag positions carry `ld_id_i`, most significant bit first (F14 = bit 1 and F15 = bit 0 by default).
- R8: Slot k is taken from `ld_slots_i[k*SLOT_W-1:(k-1)*SLOT_W]`. Slots go out in order from slot 1, each one MSB first. Slot 1 bit SLOT_W-1 (the read/write flag) is at F(TAG_W), and the last slot ends at F(FRAME-1).
- R9: A slot whose mask bit is 0 is sent as all zeros, whatever its slot word holds.
- R10: A frame with no load is all zeros, except the identifier positions, which repeat the last identifier accepted (0 after reset).
- R11: `ld_valid_i` and the load inputs have no effect on the serial output while `ld_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Link bit clock; outputs change on its rising edge |
| rst_i | input | 1 | Synchronous active-high reset |
| ld_valid_i | input | 1 | Producer offers a new frame's content |
| ld_ready_o | output | 1 | Load window, one clock per frame |
| ld_mask_i | input | SLOTS | Slot valid flags, bit k-1 is slot k |
| ld_id_i | input | ID_W | Codec identifier |
| ld_slots_i | input | SLOTS*SLOT_W | Slot words, slot 1 in the low bits |
| sync_o | output | 1 | Frame sync |
| sdout_o | output | 1 | Serial data output |

## Verification
The bench builds the block with SLOTS=4, SLOT_W=8, TAG_W=8 and ID_W=2, which gives a 40-bit frame with one reserved tag bit. At that size it can sweep every mask value against every identifier. Each frame is checked bit by bit against an arithmetic model, and so is the sync level and the load window at every position. Empty frames and mid-frame load attempts with inverted data are mixed into the sweep, so that identifier retention and the handshake gating are tested across frame boundaries.

// File: rtl/aclink_frame_tx.sv
module aclink_frame_tx #(
  parameter int SLOTS  = 12,
  parameter int SLOT_W = 20,
  parameter int TAG_W  = 16,
  parameter int ID_W   = 2
) (
  input  logic                    clk_i,
  input  logic                    rst_i,
  input  logic                    ld_valid_i,
  output logic                    ld_ready_o,
  input  logic [SLOTS-1:0]        ld_mask_i,
  input  logic [ID_W-1:0]         ld_id_i,
  input  logic [SLOTS*SLOT_W-1:0] ld_slots_i,
  output logic                    sync_o,
  output logic                    sdout_o
);
  localparam int FRAME = TAG_W + SLOTS * SLOT_W;
  localparam int PW    = $clog2(FRAME);
  localparam int RSV_LO = SLOTS + 1;
  localparam int RSV_HI = TAG_W - ID_W;

  logic [PW-1:0]    pos;
  logic [FRAME-1:0] shreg, nxt;
  logic [ID_W-1:0]  id_q;
  logic             take;

  assign ld_ready_o = (pos == PW'(FRAME - 1));
  assign take       = ld_valid_i && ld_ready_o;
  assign sdout_o    = shreg[FRAME-1];
  assign sync_o     = (pos == PW'(FRAME - 1)) || (pos < PW'(TAG_W - 1));

  always_comb begin
    nxt = '0;
    if (take) begin
      nxt[FRAME-1] = |ld_mask_i;
      for (int k = 0; k < SLOTS; k++) nxt[FRAME-2-k] = ld_mask_i[k];
    end
    for (int j = 0; j < ID_W; j++) nxt[FRAME-TAG_W+j] = take ? ld_id_i[j] : id_q[j];
    for (int s = 0; s < SLOTS; s++)
      for (int b = 0; b < SLOT_W; b++)
        nxt[(SLOTS-1-s)*SLOT_W+b] = take && ld_mask_i[s] && ld_slots_i[s*SLOT_W+b];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pos   <= PW'(FRAME - 2);
      shreg <= '0;
      id_q  <= '0;
    end else if (ld_ready_o) begin
      pos   <= '0;
      shreg <= nxt;
      if (take) id_q <= ld_id_i;
    end else begin
      pos   <= pos + 1'b1;
      shreg <= {shreg[FRAME-2:0], 1'b0};
    end
  end

  logic [PW:0] sync_run;
  always_ff @(posedge clk_i) begin
    if (rst_i)       sync_run <= '0;
    else if (sync_o) sync_run <= sync_run + 1'b1;
    else             sync_run <= '0;
  end

  AST_SYNC_WIDTH: assert property (@(posedge clk_i) disable iff (rst_i)
    $fell(sync_o) |-> sync_run == (PW+1)'(TAG_W)); // R1
  AST_SYNC_OPENS_WINDOW: assert property (@(posedge clk_i) disable iff (rst_i)
    $rose(sync_o) |-> ld_ready_o); // R3
  AST_WINDOW_WRAPS: assert property (@(posedge clk_i) disable iff (rst_i)
    ld_ready_o |=> (pos == '0) && !ld_ready_o); // R3
  AST_FRAME_VALID: assert property (@(posedge clk_i) disable iff (rst_i)
    (pos == '0) |-> sdout_o == |shreg[FRAME-2 -: SLOTS]); // R4
  AST_RESERVED_ZERO: assert property (@(posedge clk_i) disable iff (rst_i)
    (pos >= PW'(RSV_LO) && pos < PW'(RSV_HI)) |-> !sdout_o); // R6
endmodule

// File: tb/aclink_frame_tx_tb.sv
module aclink_frame_tx_tb;
  localparam int SLOTS = 4, SLOT_W = 8, TAG_W = 8, ID_W = 2;
  localparam int FRAME = TAG_W + SLOTS * SLOT_W;

  logic clk = 0, rst = 1;
  logic ld_valid = 0;
  logic [SLOTS-1:0] ld_mask = '0;
  logic [ID_W-1:0] ld_id = '0;
  logic [SLOTS*SLOT_W-1:0] ld_slots = '0;
  logic ld_ready, sync, sdout;
  int checks = 0, fails = 0, cycles = 0;
  logic [ID_W-1:0] last_id = '0;

  always #2 clk = ~clk;

  aclink_frame_tx #(.SLOTS(SLOTS), .SLOT_W(SLOT_W), .TAG_W(TAG_W), .ID_W(ID_W)) u_dut (
    .clk_i(clk), .rst_i(rst), .ld_valid_i(ld_valid), .ld_ready_o(ld_ready),
    .ld_mask_i(ld_mask), .ld_id_i(ld_id), .ld_slots_i(ld_slots),
    .sync_o(sync), .sdout_o(sdout));

  task automatic chk(input string tag, input int act, input int exp, input int p);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s pos %0d: actual %0d expected %0d", tag, p, act, exp);
    end
  endtask

  task automatic run_frame(input bit v, input logic [SLOTS-1:0] m, input logic [ID_W-1:0] id,
                           input logic [SLOTS*SLOT_W-1:0] sl, input bit junk);
    logic [SLOTS-1:0] em;
    logic [ID_W-1:0] eid;
    int exp_bit;
    string tag;
    chk("R3 ready at frame end", int'(ld_ready), 1, FRAME - 1);
    chk("R1 sync at frame end", int'(sync), 1, FRAME - 1);
    ld_valid = v; ld_mask = m; ld_id = id; ld_slots = sl;
    em  = v ? m : '0;
    eid = v ? id : last_id;
    if (v) last_id = id;
    for (int p = 0; p < FRAME; p++) begin
      @(negedge clk);
      if (junk && p < FRAME - 2) begin
        ld_valid = 1; ld_mask = ~m; ld_id = ~id; ld_slots = ~sl;
      end else ld_valid = 0;
      if (p == 0) begin
        exp_bit = int'(|em); tag = v ? "R4" : "R10";
      end else if (p <= SLOTS) begin
        exp_bit = int'(em[p-1]); tag = v ? "R5" : "R10";
      end else if (p < TAG_W - ID_W) begin
        exp_bit = 0; tag = "R6";
      end else if (p < TAG_W) begin
        exp_bit = int'(eid[TAG_W-1-p]); tag = v ? "R7" : "R10 id";
      end else begin
        int s, b;
        s = (p - TAG_W) / SLOT_W;
        b = SLOT_W - 1 - (p - TAG_W) % SLOT_W;
        exp_bit = int'(em[s] & sl[s*SLOT_W+b]);
        tag = !v ? "R10" : (m[s] ? "R8" : "R9");
      end
      if (junk) tag = {tag, " R11"};
      chk(tag, int'(sdout), exp_bit, p);
      chk("R1 sync", int'(sync), int'(p == FRAME - 1 || p <= TAG_W - 2), p);
      chk("R3 ready", int'(ld_ready), int'(p == FRAME - 1), p);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 sync in reset", int'(sync), 0, -1);
    chk("R2 sdout in reset", int'(sdout), 0, -1);
    chk("R2 ready in reset", int'(ld_ready), 0, -1);
    rst = 0;
    @(negedge clk);
    run_frame(0, '0, '0, '0, 0);
    for (int m = 0; m < 16; m++) begin
      for (int id = 0; id < 4; id++) begin
        logic [31:0] sl;
        sl = {8'(m * 29 + id * 7 + 3), 8'(m * 13 + id + 91),
              8'(id * 61 + m * 5 + 17), 8'((m * 47) ^ (id * 83))};
        run_frame(1, 4'(m), 2'(id), sl, id == 3);
        if ((m + id) % 5 == 0) run_frame(0, 4'(m), 2'(id + 1), ~sl, 0);
      end
    end
    run_frame(1, 4'hF, 2'd2, 32'hFFFF_FFFF, 0);
    run_frame(1, 4'h5, 2'd1, 32'hFFFF_FFFF, 1);
    run_frame(1, 4'h0, 2'd3, 32'hFFFF_FFFF, 0);
    run_frame(0, 4'hF, 2'd0, 32'hFFFF_FFFF, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule